// File: doc/BRIEF.md
# CSR Access Permission Checker

This block is the execute-stage handling of CSR read-modify-write instructions in a small RISC-V core that can run in a capability mode. It takes a decoded CSR operation together with its address, the rs1 operand, the current contents of the addressed CSR and several qualifying flags. From these it produces a CSR write request, the value returned to rd, and a permission fault. The fault applies to CSR accesses and to MRET. The CSR storage, trap entry and the decode of illegal CSR addresses live elsewhere.

While capability mode is active, the program counter capability must carry its system-register permission. If it does not, a CSR access or an MRET raises a dedicated permission fault rather than an illegal-instruction trap, and neither a CSR update nor an rd write-back happens. The cycle and instret counter windows in the machine and user ranges are exempt from this check.

All results are registered. They appear one clock after the cycle in which the instruction is presented.

Top module: `csr_perm_exec`

## Requirements
- R1: For op code 2'b01 (swap) the CSR write data is rs1. For 2'b10 (set) it is old OR rs1. For 2'b11 (clear) it is old AND NOT rs1. Op code 2'b00 produces neither a write nor an rd write-back. All outputs appear on the clock edge that follows the issue cycle.
- R2: A permitted access raises rd_we_o, and rd_data_o carries the CSR value as it was read before the update.
- R3: With capability mode on and the permission bit clear, a valid CSR access that is not flagged illegal and does not target an exempt address raises perm_fault_o with fault_cause_o = 2'b01. In that cycle csr_we_o and rd_we_o are both low.
- R4: The addresses 0xB00 to 0xB03 and 0xC00 to 0xC03 never fault for lack of permission. Their neighbours 0xAFF, 0xB04, 0xBFF and 0xC04 are checked as normal.
- R5: When the illegal flag is set, or instr_valid_i is low, the block produces no fault, no CSR write and no rd write-back.
- R6: A valid MRET with capability mode on and the permission bit clear raises perm_fault_o with fault_cause_o = 2'b10. With the permission bit set, or with capability mode off, MRET does not fault.
- R7: With capability mode off, the permission bit has no effect, and every legal access proceeds.
- R8: A set or clear operation whose rs1 operand is register x0 performs no CSR write, but rd is still written.
- R9: Address 0x306 reads as zero to rd and is never written.
- R10: After reset every output is zero. The fault lasts only for the output cycle of the faulting instruction and drops on the next cycle when no further fault is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction in execute is valid |
| illegal_i | input | 1 | Decode flagged the instruction as illegal |
| csr_access_i | input | 1 | Instruction is a CSR read-modify-write |
| mret_i | input | 1 | Instruction is MRET |
| op_i | input | 2 | CSR operation: 01 swap, 10 set, 11 clear |
| rs1_is_x0_i | input | 1 | rs1 register index is x0 |
| csr_addr_i | input | 12 | CSR address |
| rs1_val_i | input | 32 | rs1 operand value |
| csr_rdata_i | input | 32 | Current contents of the addressed CSR |
| cap_mode_i | input | 1 | Capability mode enabled |
| pcc_sysreg_perm_i | input | 1 | System-register permission of the PC capability |
| csr_we_o | output | 1 | CSR write enable |
| csr_waddr_o | output | 12 | CSR write address |
| csr_wdata_o | output | 32 | CSR write data |
| rd_we_o | output | 1 | rd write-back enable |
| rd_data_o | output | 32 | rd write-back value |
| perm_fault_o | output | 1 | Permission fault pulse |
| fault_cause_o | output | 2 | 00 none, 01 CSR access, 10 MRET |

## Verification
The assertions rely on three properties of the inputs. First, csr_access_i and mret_i are never raised together. Second, mret_i is only raised along with instr_valid_i. Third, inputs are stable across the clock edge, so $past of an input is the value the instruction was issued with. The stimulus respects all three. Random instructions draw exactly one kind (CSR access, MRET or bubble) and hold inputs from one falling edge to the next. Each random instruction is also drawn with its own address from a pool that includes the exempt windows and their neighbours. Directed cases then cover the window edges, the zero-reading address, x0 operands and the return of the fault line to zero.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_CSR  = 2'b01,
        CAUSE_MRET = 2'b10
    } fault_cause_e;

endpackage

// File: rtl/csr_perm_gate.sv
// Permission decision: exempt-window decode and fault qualification.
module csr_perm_gate #(
    parameter int                        ADDR_W    = 12,
    parameter int                        NUM_WIN   = 2,
    parameter int                        WIN_SIZE  = 4,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {12'hC00, 12'hB00}
) (
    input  logic              valid_i,
    input  logic              illegal_i,
    input  logic              csr_access_i,
    input  logic              mret_i,
    input  logic              cap_mode_i,
    input  logic              perm_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              csr_fault_o,
    output logic              mret_fault_o,
    output logic              access_ok_o
);
    localparam int CMP_W = ADDR_W + 1;

    logic [NUM_WIN-1:0] win_hit;

    // One comparator pair per exempt window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = WIN_BASES[g*ADDR_W +: ADDR_W];
        localparam logic [CMP_W-1:0]  LO   = {1'b0, BASE};
        localparam logic [CMP_W-1:0]  HI   = LO + CMP_W'(WIN_SIZE);
        logic [CMP_W-1:0] a_ext;
        assign a_ext      = {1'b0, addr_i};
        assign win_hit[g] = (a_ext >= LO) && (a_ext < HI);
    end

    logic exempt;
    logic lacks_perm;
    logic live_csr;
    logic live_mret;

    always_comb begin
        exempt       = |win_hit;
        lacks_perm   = cap_mode_i && !perm_i;
        live_mret    = valid_i && mret_i;
        live_csr     = valid_i && csr_access_i && !illegal_i && !mret_i;
        mret_fault_o = live_mret && lacks_perm;
        csr_fault_o  = live_csr && lacks_perm && !exempt;
        access_ok_o  = live_csr && !(lacks_perm && !exempt);
    end

endmodule

// File: rtl/csr_rmw_unit.sv
// Read-modify-write datapath: new value, write request, rd value.
module csr_rmw_unit
    import csr_perm_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] ZERO_ADDR = 12'h306
) (
    input  logic              access_ok_i,
    input  logic [1:0]        op_i,
    input  logic              rs1_is_x0_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [XLEN-1:0]   rs1_i,
    input  logic [XLEN-1:0]   old_i,
    output logic              we_o,
    output logic [XLEN-1:0]   wdata_o,
    output logic              rd_we_o,
    output logic [XLEN-1:0]   rd_data_o
);
    csr_op_e      op;
    logic         is_zero_csr;
    logic [XLEN-1:0] seen;

    always_comb begin
        op          = csr_op_e'(op_i);
        is_zero_csr = (addr_i == ZERO_ADDR);
        seen        = is_zero_csr ? '0 : old_i;
        unique case (op)
            OP_SWAP: wdata_o = rs1_i;
            OP_SET:  wdata_o = seen | rs1_i;
            OP_CLR:  wdata_o = seen & ~rs1_i;
            default: wdata_o = seen;
        endcase
        rd_we_o   = access_ok_i && (op != OP_NONE);
        rd_data_o = seen;
        we_o      = rd_we_o && !is_zero_csr &&
                    !((op != OP_SWAP) && rs1_is_x0_i);
    end

endmodule

// File: rtl/csr_perm_exec.sv
module csr_perm_exec
    import csr_perm_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid_i,
    input  logic              illegal_i,
    input  logic              csr_access_i,
    input  logic              mret_i,
    input  logic [1:0]        op_i,
    input  logic              rs1_is_x0_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   rs1_val_i,
    input  logic [XLEN-1:0]   csr_rdata_i,
    input  logic              cap_mode_i,
    input  logic              pcc_sysreg_perm_i,
    output logic              csr_we_o,
    output logic [ADDR_W-1:0] csr_waddr_o,
    output logic [XLEN-1:0]   csr_wdata_o,
    output logic              rd_we_o,
    output logic [XLEN-1:0]   rd_data_o,
    output logic              perm_fault_o,
    output logic [1:0]        fault_cause_o
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [XLEN-1:0]   wdata;
        logic              rd_we;
        logic [XLEN-1:0]   rd_data;
        logic              fault;
        fault_cause_e      cause;
    } out_state_t;

    logic            csr_fault;
    logic            mret_fault;
    logic            access_ok;
    logic            rmw_we;
    logic [XLEN-1:0] rmw_wdata;
    logic            rmw_rd_we;
    logic [XLEN-1:0] rmw_rd_data;

    csr_perm_gate #(
        .ADDR_W  (ADDR_W),
        .NUM_WIN (2),
        .WIN_SIZE(4),
        .WIN_BASES({ADDR_W'(12'hC00), ADDR_W'(12'hB00)})
    ) u_gate (
        .valid_i     (instr_valid_i),
        .illegal_i   (illegal_i),
        .csr_access_i(csr_access_i),
        .mret_i      (mret_i),
        .cap_mode_i  (cap_mode_i),
        .perm_i      (pcc_sysreg_perm_i),
        .addr_i      (csr_addr_i),
        .csr_fault_o (csr_fault),
        .mret_fault_o(mret_fault),
        .access_ok_o (access_ok)
    );

    csr_rmw_unit #(
        .XLEN     (XLEN),
        .ADDR_W   (ADDR_W),
        .ZERO_ADDR(ADDR_W'(12'h306))
    ) u_rmw (
        .access_ok_i(access_ok),
        .op_i       (op_i),
        .rs1_is_x0_i(rs1_is_x0_i),
        .addr_i     (csr_addr_i),
        .rs1_i      (rs1_val_i),
        .old_i      (csr_rdata_i),
        .we_o       (rmw_we),
        .wdata_o    (rmw_wdata),
        .rd_we_o    (rmw_rd_we),
        .rd_data_o  (rmw_rd_data)
    );

    out_state_t st_d, st_q;

    always_comb begin
        st_d         = '0;
        st_d.we      = rmw_we;
        st_d.waddr   = rmw_we ? csr_addr_i : '0;
        st_d.wdata   = rmw_we ? rmw_wdata : '0;
        st_d.rd_we   = rmw_rd_we;
        st_d.rd_data = rmw_rd_we ? rmw_rd_data : '0;
        st_d.fault   = csr_fault || mret_fault;
        if (mret_fault)     st_d.cause = CAUSE_MRET;
        else if (csr_fault) st_d.cause = CAUSE_CSR;
        else                st_d.cause = CAUSE_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr_we_o      = st_q.we;
    assign csr_waddr_o   = st_q.waddr;
    assign csr_wdata_o   = st_q.wdata;
    assign rd_we_o       = st_q.rd_we;
    assign rd_data_o     = st_q.rd_data;
    assign perm_fault_o  = st_q.fault;
    assign fault_cause_o = st_q.cause;

endmodule

// File: rtl/csr_perm_exec_chk.sv
module csr_perm_exec_chk #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid_i,
    input logic              illegal_i,
    input logic              mret_i,
    input logic [1:0]        op_i,
    input logic              rs1_is_x0_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic              cap_mode_i,
    input logic              pcc_sysreg_perm_i,
    input logic              csr_we_o,
    input logic [ADDR_W-1:0] csr_waddr_o,
    input logic              rd_we_o,
    input logic              perm_fault_o,
    input logic [1:0]        fault_cause_o
);
    AST_FAULT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        perm_fault_o |-> (!csr_we_o && !rd_we_o)); // R3
    AST_CAUSE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        perm_fault_o == (fault_cause_o != 2'b00)); // R6
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_cause_o)); // R3
    AST_EXEMPT_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_fault_o && fault_cause_o == 2'b01) |->
            ($past(csr_addr_i[ADDR_W-1:2]) != 10'h2C0 &&
             $past(csr_addr_i[ADDR_W-1:2]) != 10'h300)); // R4
    AST_FAULT_NEEDS_CAPMODE: assert property (@(posedge clk) disable iff (!rst_n)
        perm_fault_o |-> ($past(cap_mode_i) && !$past(pcc_sysreg_perm_i))); // R7
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(illegal_i) && !$past(mret_i)) |->
            (!csr_we_o && !rd_we_o && !perm_fault_o)); // R5
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(instr_valid_i) |-> (!csr_we_o && !rd_we_o && !perm_fault_o)); // R5
    AST_ZERO_CSR_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we_o |-> (csr_waddr_o != ADDR_W'(12'h306))); // R9
    AST_X0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we_o |-> ($past(op_i) == 2'b01 || !$past(rs1_is_x0_i))); // R8
    AST_WRITE_HAS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we_o |-> rd_we_o); // R2
endmodule

bind csr_perm_exec csr_perm_exec_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .instr_valid_i    (instr_valid_i),
    .illegal_i        (illegal_i),
    .mret_i           (mret_i),
    .op_i             (op_i),
    .rs1_is_x0_i      (rs1_is_x0_i),
    .csr_addr_i       (csr_addr_i),
    .cap_mode_i       (cap_mode_i),
    .pcc_sysreg_perm_i(pcc_sysreg_perm_i),
    .csr_we_o         (csr_we_o),
    .csr_waddr_o      (csr_waddr_o),
    .rd_we_o          (rd_we_o),
    .perm_fault_o     (perm_fault_o),
    .fault_cause_o    (fault_cause_o)
);

// File: tb/csr_perm_exec_test.sv
module csr_perm_exec_test;
    localparam int NADDR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic        illegal_i = 1'b0;
    logic        csr_access_i = 1'b0;
    logic        mret_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        rs1_is_x0_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] rs1_val_i = '0;
    logic [31:0] csr_rdata_i = '0;
    logic        cap_mode_i = 1'b0;
    logic        pcc_sysreg_perm_i = 1'b0;
    logic        csr_we_o;
    logic [11:0] csr_waddr_o;
    logic [31:0] csr_wdata_o;
    logic        rd_we_o;
    logic [31:0] rd_data_o;
    logic        perm_fault_o;
    logic [1:0]  fault_cause_o;

    int checks = 0;
    int fails  = 0;
    logic [11:0] pool [NADDR];
    logic [31:0] mem  [NADDR];

    always #4 clk = ~clk;

    csr_perm_exec uut (.*);

    task automatic report();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        report();
    end

    function automatic bit is_exempt(logic [11:0] a);
        return (a >= 12'hB00 && a <= 12'hB03) || (a >= 12'hC00 && a <= 12'hC03);
    endfunction

    // Expected output vector {we, waddr, wdata, rd_we, rd_data, fault, cause}
    function automatic logic [80:0] expect_out(
        bit v, bit ill, bit acc, bit mr, logic [1:0] op, bit x0,
        logic [11:0] a, logic [31:0] rs1, logic [31:0] old, bit cap, bit perm);
        bit          nogo = cap && !perm;
        bit          we = 0, rdw = 0, flt = 0;
        logic [1:0]  cause = 2'b00;
        logic [31:0] seen = (a == 12'h306) ? 32'h0 : old;
        logic [31:0] nv = 32'h0;
        if (v && mr) begin
            if (nogo) begin flt = 1; cause = 2'b10; end
        end else if (v && acc && !ill) begin
            if (nogo && !is_exempt(a)) begin
                flt = 1; cause = 2'b01;
            end else if (op != 2'b00) begin
                rdw = 1;
                case (op)
                    2'b01:   nv = rs1;
                    2'b10:   nv = seen | rs1;
                    default: nv = seen & ~rs1;
                endcase
                we = (a != 12'h306) && !(op != 2'b01 && x0);
            end
        end
        return {we, we ? a : 12'h0, we ? nv : 32'h0, rdw, rdw ? seen : 32'h0, flt, cause};
    endfunction

    task automatic check(string tag, logic [80:0] got, logic [80:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [80:0] outs();
        return {csr_we_o, csr_waddr_o, csr_wdata_o, rd_we_o, rd_data_o, perm_fault_o, fault_cause_o};
    endfunction

    // Drive at a falling edge, check results at the next falling edge.
    task automatic issue(string tag, int idx, bit v, bit ill, bit acc, bit mr,
                         logic [1:0] op, bit x0, logic [31:0] rs1, bit cap, bit perm);
        logic [80:0] e;
        instr_valid_i = v; illegal_i = ill; csr_access_i = acc; mret_i = mr;
        op_i = op; rs1_is_x0_i = x0; csr_addr_i = pool[idx]; rs1_val_i = rs1;
        csr_rdata_i = mem[idx]; cap_mode_i = cap; pcc_sysreg_perm_i = perm;
        e = expect_out(v, ill, acc, mr, op, x0, pool[idx], rs1, mem[idx], cap, perm);
        @(negedge clk);
        instr_valid_i = 0; csr_access_i = 0; mret_i = 0; illegal_i = 0;
        check(tag, outs(), e);
        if (csr_we_o) mem[idx] = csr_wdata_o;
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        check(tag, outs(), 81'h0);
    endtask

    initial begin
        pool = '{12'h300, 12'h305, 12'h340, 12'h341, 12'h306, 12'hB00,
                 12'hB03, 12'hC02, 12'hAFF, 12'hB04, 12'hBFF, 12'hC04};
        for (int i = 0; i < NADDR; i++) mem[i] = 32'h1000_0000 + 32'(i * 32'h0101);
        void'($urandom(32'd7001));
        repeat (3) @(negedge clk);
        check("R10", outs(), 81'h0);   // R10 reset state
        rst_n = 1;
        @(negedge clk);

        // R1 each operation, capability mode off
        issue("R1", 0, 1, 0, 1, 0, 2'b01, 0, 32'hA5A5_0F0F, 0, 0);
        issue("R1", 0, 1, 0, 1, 0, 2'b10, 0, 32'h0000_F000, 0, 0);
        issue("R1", 0, 1, 0, 1, 0, 2'b11, 0, 32'h0000_0F00, 0, 0);
        issue("R1", 1, 1, 0, 1, 0, 2'b00, 0, 32'hFFFF_FFFF, 0, 0);
        // R2 rd gets the pre-update value
        issue("R2", 2, 1, 0, 1, 0, 2'b01, 0, 32'h1234_5678, 1, 1);
        issue("R2", 2, 1, 0, 1, 0, 2'b01, 0, 32'h0, 1, 1);
        // R3 fault and R10 pulse drop
        issue("R3", 3, 1, 0, 1, 0, 2'b01, 0, 32'hDEAD_BEEF, 1, 0);
        idle_check("R10");
        issue("R3", 3, 1, 0, 1, 0, 2'b10, 0, 32'h1, 1, 0);
        // R4 window edges
        for (int i = 5; i < 12; i++)
            issue("R4", i, 1, 0, 1, 0, 2'b10, 0, 32'h8000_0001, 1, 0);
        // R5 illegal and invalid are quiet
        issue("R5", 3, 1, 1, 1, 0, 2'b01, 0, 32'hFFFF, 1, 0);
        issue("R5", 3, 0, 0, 1, 0, 2'b01, 0, 32'hFFFF, 0, 0);
        // R6 MRET
        issue("R6", 0, 1, 0, 0, 1, 2'b00, 0, 32'h0, 1, 0);
        idle_check("R10");
        issue("R6", 0, 1, 0, 0, 1, 2'b00, 0, 32'h0, 1, 1);
        issue("R6", 0, 1, 0, 0, 1, 2'b00, 0, 32'h0, 0, 0);
        // R7 permission ignored with capability mode off
        issue("R7", 3, 1, 0, 1, 0, 2'b11, 0, 32'h0000_00FF, 0, 0);
        // R8 x0 operand
        issue("R8", 1, 1, 0, 1, 0, 2'b10, 1, 32'hFFFF_FFFF, 0, 0);
        issue("R8", 1, 1, 0, 1, 0, 2'b11, 1, 32'hFFFF_FFFF, 1, 1);
        issue("R8", 1, 1, 0, 1, 0, 2'b01, 1, 32'h0, 0, 0);
        // R9 zero-reading address
        mem[4] = 32'hCAFE_F00D;
        issue("R9", 4, 1, 0, 1, 0, 2'b01, 0, 32'h7777_7777, 0, 0);
        issue("R9", 4, 1, 0, 1, 0, 2'b10, 0, 32'h1, 1, 1);

        // R1 mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int          kind = $urandom_range(0, 9);
            int          idx  = $urandom_range(0, NADDR - 1);
            logic [1:0]  op   = 2'($urandom_range(1, 3));
            bit          x0   = ($urandom_range(0, 3) == 0);
            logic [31:0] rs1  = x0 ? 32'h0 : $urandom;
            bit          cap  = 1'($urandom);
            bit          perm = 1'($urandom);
            bit          ill  = ($urandom_range(0, 7) == 0);
            if (kind == 0)      issue("R6", idx, 1, 0, 0, 1, 2'b00, 0, 32'h0, cap, perm);
            else if (kind == 1) issue("R5", idx, 0, ill, 1, 0, op, x0, rs1, cap, perm);
            else                issue("R1", idx, 1, ill, 1, 0, op, x0, rs1, cap, perm);
        end
        idle_check("R10");
        report();
    end
endmodule